// File: doc/BRIEF.md
# Synchronizable PWM Engine

This block turns a commanded duty fraction into one pulse-width-modulated gate-drive output. A free-running period counter, clocked by the system clock, runs from zero up to the programmed period minus one. A compare threshold is formed as the duty fraction times the period, trimmed by a signed current-balance offset and saturated. A set/reset output register raises the gate at the start of every period and drops it when the counter reaches the threshold.

The same counter also drives the timing signals around the gate. A one-clock sync output marks each period start so that a second engine can follow this one. A synchronized rising edge on the sync input restarts the period at once. A one-clock converter trigger fires at a programmable offset inside each period. The duty, period, trigger offset and balance trim are captured only at a period boundary, so a command that changes mid-period never cuts a pulse short.

Top module: `sync_pwm_engine`

## Requirements
- R1: The period length P equals the period command, with any command below 2 treated as 2. The counter runs 0..P-1, and `syncOut` is a one-clock pulse in the first cycle of every period, so consecutive `syncOut` pulses are P cycles apart.
- R2: `dutyCmd` is unsigned with 4096 meaning 100%. The threshold is floor(duty*P/4096) plus the trim, and `gateOut` is high for exactly that many cycles per period, starting in the `syncOut` cycle.
- R3: A duty above 4096 is clamped to 4096. A threshold of 0 keeps `gateOut` low for the whole period, and a threshold of P keeps it high for the whole period.
- R4: `balAdj` is a 10-bit two's-complement trim added after scaling. The sum saturates to 0 when negative and to P when above P.
- R5: `adcTrig` is a one-clock pulse exactly `trigCmd` cycles after the `syncOut` cycle, once per period. If `trigCmd` >= P, no trigger fires in that period.
- R6: Every command is double-buffered. A change made in the middle of a period leaves that period unchanged and takes effect from the next period.
- R7: A rising edge on `syncIn` passes through a two-flop synchronizer and restarts the counter, which also loads the pending commands. When `syncIn` is driven right after a clock edge, `syncOut` is visible after the fourth following edge. Holding `syncIn` high does not restart the counter again.
- R8: While `rstN` is low, `gateOut`, `syncOut` and `adcTrig` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| dutyCmd | input | 13 | Duty fraction, 4096 = 100% |
| periodCmd | input | 16 | Switching period in clocks |
| trigCmd | input | 16 | Converter-trigger offset within the period |
| balAdj | input | 10 | Signed current-balance trim in clocks |
| syncIn | input | 1 | Asynchronous period-restart request |
| gateOut | output | 1 | PWM gate-drive output |
| syncOut | output | 1 | One-clock period-start pulse |
| adcTrig | output | 1 | One-clock converter sample trigger |

## Verification
The bench checks full periods at both ends of the duty range and when the trim saturates up or down. A design that compares with the wrong inequality would give one extra or one missing gate cycle, or a glitch at 0% or 100%. It changes commands mid-period and checks that the period already running keeps its old shape, which catches any design that loads its shadow copies on every clock. It also checks the exact latency from a sync edge to the restart and keeps `syncIn` high over later periods, so a level-sensitive restart or a missing synchronizer stage shows up as a wrong period length or a shifted pulse.

// File: rtl/spwm_pkg.sv
`timescale 1ns/1ps
package spwm_pkg;
  // Strobes from the counter control to the datapath
  typedef struct packed {
    logic load;         // period boundary: capture the pending commands
    logic periodStart;  // counter is at zero in this cycle
  } pwmStrobe_t;
endpackage

// File: rtl/spwm_ctrl.sv
`timescale 1ns/1ps
module spwm_ctrl
  import spwm_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             syncIn,
  input  logic [CNT_W-1:0] periodAct,
  output logic [CNT_W-1:0] cnt,
  output pwmStrobe_t       strobe,
  output logic             syncEdge,
  output logic             syncOut
);
  // Synchronizer stages plus one extra flop for edge detection
  logic [SYNC_STAGES:0] syncPipe;
  logic atEnd;
  logic wrap;

  always_ff @(posedge clk) begin
    if (!rstN) syncPipe <= '0;
    else       syncPipe <= {syncPipe[SYNC_STAGES-1:0], syncIn};
  end

  assign syncEdge = syncPipe[SYNC_STAGES-1] & ~syncPipe[SYNC_STAGES];

  assign atEnd = (cnt >= periodAct - 1'b1);
  assign wrap  = atEnd | syncEdge;

  always_comb begin
    strobe.load        = wrap;
    strobe.periodStart = (cnt == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN)     cnt <= '0;
    else if (wrap) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) syncOut <= 1'b0;
    else       syncOut <= strobe.periodStart;
  end
endmodule

// File: rtl/spwm_datapath.sv
`timescale 1ns/1ps
module spwm_datapath
  import spwm_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int FRAC_W     = 12,
  parameter int ADJ_W      = 10,
  parameter int MIN_PERIOD = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [FRAC_W:0]         dutyCmd,
  input  logic [CNT_W-1:0]        periodCmd,
  input  logic [CNT_W-1:0]        trigCmd,
  input  logic signed [ADJ_W-1:0] balAdj,
  input  logic [CNT_W-1:0]        cnt,
  input  pwmStrobe_t              strobe,
  output logic [CNT_W-1:0]        periodAct,
  output logic [CNT_W-1:0]        thrAct,
  output logic [CNT_W-1:0]        trigAct,
  output logic                    gateOut,
  output logic                    adcTrig
);
  localparam int DUTY_W = FRAC_W + 1;
  localparam int FULL   = 1 << FRAC_W;
  localparam int PROD_W = DUTY_W + CNT_W;
  localparam int SUM_W  = PROD_W + 1;

  logic [DUTY_W-1:0]       dutyClamp;
  logic [CNT_W-1:0]        periodEff;
  logic [PROD_W-1:0]       prod;
  logic signed [SUM_W-1:0] sumVal;
  logic [CNT_W-1:0]        thrNext;

  // Pending-command conditioning
  always_comb begin
    dutyClamp = (dutyCmd > DUTY_W'(FULL)) ? DUTY_W'(FULL) : dutyCmd;
    periodEff = (periodCmd < CNT_W'(MIN_PERIOD)) ? CNT_W'(MIN_PERIOD) : periodCmd;
    prod      = PROD_W'(dutyClamp) * PROD_W'(periodEff);
    sumVal    = $signed({1'b0, prod >> FRAC_W}) + SUM_W'(balAdj);
    if (sumVal < 0)
      thrNext = '0;
    else if (sumVal > $signed({{(SUM_W-CNT_W){1'b0}}, periodEff}))
      thrNext = periodEff;
    else
      thrNext = sumVal[CNT_W-1:0];
  end

  // Shadow copies, captured only at a period boundary
  always_ff @(posedge clk) begin
    if (!rstN) begin
      periodAct <= CNT_W'(MIN_PERIOD);
      thrAct    <= '0;
      trigAct   <= '1;
    end else if (strobe.load) begin
      periodAct <= periodEff;
      thrAct    <= thrNext;
      trigAct   <= trigCmd;
    end
  end

  // Set/reset output register: reset wins so a zero threshold stays low
  always_ff @(posedge clk) begin
    if (!rstN)                   gateOut <= 1'b0;
    else if (cnt == thrAct)      gateOut <= 1'b0;
    else if (strobe.periodStart) gateOut <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) adcTrig <= 1'b0;
    else       adcTrig <= (cnt == trigAct);
  end
endmodule

// File: rtl/sync_pwm_engine.sv
`timescale 1ns/1ps
module sync_pwm_engine
  import spwm_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int FRAC_W      = 12,
  parameter int ADJ_W       = 10,
  parameter int SYNC_STAGES = 2,
  parameter int MIN_PERIOD  = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [FRAC_W:0]         dutyCmd,
  input  logic [CNT_W-1:0]        periodCmd,
  input  logic [CNT_W-1:0]        trigCmd,
  input  logic signed [ADJ_W-1:0] balAdj,
  input  logic                    syncIn,
  output logic                    gateOut,
  output logic                    syncOut,
  output logic                    adcTrig
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] periodAct;
  logic [CNT_W-1:0] thrAct;
  logic [CNT_W-1:0] trigAct;
  logic             syncEdge;
  pwmStrobe_t       strobe;

  spwm_ctrl #(
    .CNT_W(CNT_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) uCtrl (
    .clk(clk),
    .rstN(rstN),
    .syncIn(syncIn),
    .periodAct(periodAct),
    .cnt(cnt),
    .strobe(strobe),
    .syncEdge(syncEdge),
    .syncOut(syncOut)
  );

  spwm_datapath #(
    .CNT_W(CNT_W),
    .FRAC_W(FRAC_W),
    .ADJ_W(ADJ_W),
    .MIN_PERIOD(MIN_PERIOD)
  ) uDp (
    .clk(clk),
    .rstN(rstN),
    .dutyCmd(dutyCmd),
    .periodCmd(periodCmd),
    .trigCmd(trigCmd),
    .balAdj(balAdj),
    .cnt(cnt),
    .strobe(strobe),
    .periodAct(periodAct),
    .thrAct(thrAct),
    .trigAct(trigAct),
    .gateOut(gateOut),
    .adcTrig(adcTrig)
  );
endmodule

// File: rtl/sync_pwm_engine_chk.sv
`timescale 1ns/1ps
module sync_pwm_engine_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] periodAct,
  input logic [CNT_W-1:0] thrAct,
  input logic [CNT_W-1:0] trigAct,
  input logic             load,
  input logic             syncEdge,
  input logic             gateOut,
  input logic             syncOut
);
  // R1
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    cnt < periodAct);

  // R1
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cnt == periodAct - 1'b1) |=> (cnt == '0));

  // R7
  sync_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    syncEdge |=> (cnt == '0));

  // R6
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !load |=> ($stable(periodAct) && $stable(thrAct) && $stable(trigAct)));

  // R4
  thr_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    thrAct <= periodAct);

  // R2
  gate_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gateOut) |-> syncOut);
endmodule

bind sync_pwm_engine sync_pwm_engine_chk #(.CNT_W(CNT_W)) uChk (
  .clk(clk),
  .rstN(rstN),
  .cnt(cnt),
  .periodAct(periodAct),
  .thrAct(thrAct),
  .trigAct(trigAct),
  .load(strobe.load),
  .syncEdge(syncEdge),
  .gateOut(gateOut),
  .syncOut(syncOut)
);

// File: tb/sim_sync_pwm_engine.sv
`timescale 1ns/1ps
module sim_sync_pwm_engine;
  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic [12:0]        dutyCmd = '0;
  logic [15:0]        periodCmd = 16'd100;
  logic [15:0]        trigCmd = '0;
  logic signed [9:0]  balAdj = '0;
  logic               syncIn = 1'b0;
  logic               gateOut, syncOut, adcTrig;

  always #2.5 clk = ~clk;

  sync_pwm_engine u0 (
    .clk(clk), .rstN(rstN), .dutyCmd(dutyCmd), .periodCmd(periodCmd),
    .trigCmd(trigCmd), .balAdj(balAdj), .syncIn(syncIn),
    .gateOut(gateOut), .syncOut(syncOut), .adcTrig(adcTrig)
  );

  typedef struct {
    int    len;
    int    high;
    int    trigCnt;
    int    trigPos;
    string tag;
  } period_t;

  period_t expQ[$];
  int tests = 0;
  int fails = 0;
  bit recActive = 1'b0;
  int recLen, recHigh, recTrigCnt, recTrigPos;

  function automatic period_t mkExp(int duty, int per, int trig, int adj, string tag);
    period_t e;
    int d = (duty > 4096) ? 4096 : duty;
    int p = (per < 2) ? 2 : per;
    int t = (d * p) / 4096 + adj;
    if (t < 0) t = 0;
    if (t > p) t = p;
    e.len = p;
    e.high = t;
    e.trigCnt = (trig < p) ? 1 : 0;
    e.trigPos = (trig < p) ? trig : -1;
    e.tag = tag;
    return e;
  endfunction

  // Monitor: measure each period between syncOut pulses and score it
  always @(negedge clk) begin
    period_t e;
    if (rstN) begin
      if (syncOut) begin
        if (recActive && expQ.size() > 0) begin
          e = expQ.pop_front();
          tests++;
          if (recLen != e.len || recHigh != e.high ||
              recTrigCnt != e.trigCnt || recTrigPos != e.trigPos) begin
            fails++;
            $display("FAIL %s: len/high/trigCnt/trigPos got %0d/%0d/%0d/%0d expected %0d/%0d/%0d/%0d",
                     e.tag, recLen, recHigh, recTrigCnt, recTrigPos,
                     e.len, e.high, e.trigCnt, e.trigPos);
          end
        end
        recActive  = 1'b1;
        recLen     = 1;
        recHigh    = gateOut ? 1 : 0;
        recTrigCnt = adcTrig ? 1 : 0;
        recTrigPos = adcTrig ? 0 : -1;
      end else if (recActive) begin
        recLen++;
        if (gateOut) recHigh++;
        if (adcTrig) begin
          if (recTrigCnt == 0) recTrigPos = recLen - 1;
          recTrigCnt++;
        end
      end
    end
  end

  task automatic checkBit(string tag, logic got, logic exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b", tag, got, exp);
    end
  endtask

  task automatic setCmd(int duty, int per, int trig, int adj);
    dutyCmd   = 13'(duty);
    periodCmd = 16'(per);
    trigCmd   = 16'(trig);
    balAdj    = 10'(adj);
  endtask

  task automatic waitStart();
    do @(negedge clk); while (!syncOut);
  endtask

  task automatic waitDrain();
    while (expQ.size() > 0) @(posedge clk);
  endtask

  // Driver: apply commands, wait for the first period that uses them, queue expectations
  task automatic runCase(int duty, int per, int trig, int adj, int n, string tag);
    waitDrain();
    @(negedge clk);
    setCmd(duty, per, trig, adj);
    @(negedge clk);
    waitStart();
    @(posedge clk);
    for (int i = 0; i < n; i++) expQ.push_back(mkExp(duty, per, trig, adj, tag));
  endtask

  initial begin
    // R8: outputs held low in reset
    setCmd(2048, 100, 0, 0);
    repeat (5) @(negedge clk);
    checkBit("R8 gateOut in reset", gateOut, 1'b0);
    checkBit("R8 syncOut in reset", syncOut, 1'b0);
    checkBit("R8 adcTrig in reset", adcTrig, 1'b0);
    rstN = 1'b1;

    runCase(2048, 100, 30, 0, 2, "R2 half duty");
    runCase(1000, 200, 0, 0, 2, "R2 truncated product");
    runCase(0, 100, 10, 0, 1, "R3 zero duty");
    runCase(4096, 100, 99, 0, 1, "R3 full duty");
    runCase(5000, 80, 5, 0, 1, "R3 clamped duty");
    runCase(4000, 100, 50, 20, 1, "R4 upper saturation");
    runCase(400, 100, 50, -30, 1, "R4 lower saturation");
    runCase(2048, 100, 50, -7, 1, "R4 negative trim");
    runCase(2048, 1, 0, 0, 3, "R1 minimum period");
    runCase(3000, 37, 36, 3, 2, "R1 odd period");
    runCase(2048, 100, 150, 0, 1, "R5 trigger beyond period");

    // R6: mid-period change must not disturb the running period
    waitDrain();
    @(negedge clk);
    setCmd(1024, 120, 40, 0);
    @(negedge clk);
    waitStart();
    @(posedge clk);
    expQ.push_back(mkExp(1024, 120, 40, 0, "R6 running period kept"));
    repeat (30) @(negedge clk);
    setCmd(3072, 90, 10, 5);
    @(posedge clk);
    expQ.push_back(mkExp(3072, 90, 10, 5, "R6 next period updated"));

    // R7: forced restart through the synchronizer
    waitDrain();
    @(negedge clk);
    setCmd(2048, 100, 20, 0);
    @(negedge clk);
    waitStart();
    repeat (20) @(negedge clk);
    setCmd(1024, 60, 15, 0);
    syncIn = 1'b1;
    for (int i = 1; i <= 3; i++) begin
      @(negedge clk);
      checkBit("R7 no early restart", syncOut, 1'b0);
    end
    @(negedge clk);
    checkBit("R7 restart latency", syncOut, 1'b1);
    @(posedge clk);
    for (int i = 0; i < 3; i++) expQ.push_back(mkExp(1024, 60, 15, 0, "R7 held sync no retrigger"));
    waitDrain();
    syncIn = 1'b0;

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule